// File: doc/BRIEF.md
# Tree Routing Multiplexer with Per-Level Select Decoders

This block is one switch point of a programmable interconnect: a parameterized N-input multiplexer that forwards exactly one of its data inputs to a single output. The input set can be widened by one extra input that is tied to a fixed logic value. This input always sits at the highest index and serves as the idle route. The selection is made by a tree of stages with a fan-in of `RADIX`. All stages on one tree level share one group of select lines, and at most one line of a group may be active.

A small configuration register holds the select information as one packed word, with one field per level and level 0 in the least significant bits. A level field is either the raw one-hot group, or, with local encoding switched on, a compact binary branch number that a per-level decoder turns back into one-hot. A level with only two branches is always driven by one plain bit. A combinational path encoder sits beside the datapath. It turns a requested input index into the matching configuration word, so the word can be produced and then written through the configuration port. At reset the register takes the word of the idle route, so the output is defined before anything is loaded.

Top module: `route_mux`

## Requirements
- R1: After a word for index p < `N_DATA` is loaded, `dout` equals `din[p]` for any data pattern.
- R2: With `ADD_CONST` set, index `N_DATA` (the last input) routes `CONST_VAL` to `dout` independently of `din`.
- R3: Each level activates at most one branch; a level field that selects no branch (an all-zero raw group, or a binary address not below that level's fan-in) drives `dout` to 0.
- R4: The digit of level l is (p / RADIX^l) mod RADIX, and the fan-in of level l is min(RADIX, ceil(NI / RADIX^l)). A level with fan-in 2 stores that digit as one bit. Otherwise the field is the digit in binary on ceil(log2(fan-in)) bits when `LOCAL_ENC` is set, or a one-hot group with bit `digit` set when it is clear. Fields are packed from level 0 at bit 0 upward.
- R5: For `req_idx` below the implemented input count NI, `req_cfg` equals the R4 word of `req_idx` and `req_err` is 0, in the same cycle.
- R6: On a rising `clk` edge with `cfg_we` high the register takes `cfg_in`; with `cfg_we` low it keeps its value whatever `cfg_in` does.
- R7: After reset the register holds the R4 word of the idle route: index `N_DATA` when `ADD_CONST` is set, index 0 otherwise.
- R8: For `req_idx` >= NI the encoder raises `req_err` and emits the idle-route word of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the configuration register |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write enable of the configuration register |
| cfg_in | input | CW | Configuration word to store |
| din | input | N_DATA | Data inputs |
| dout | output | 1 | Routed output |
| req_idx | input | IW | Input index to encode |
| req_cfg | output | CW | Configuration word for `req_idx` |
| req_err | output | 1 | `req_idx` is outside the implemented inputs |

## Verification
The path encoder and the configuration write can act in the same cycle, and the encoder must neither disturb nor be disturbed by the write. Each load is therefore issued while the encoder is asked for an out-of-range index. In that cycle the bench expects the error flag and the idle-route word, and on the next cycle it expects the output to follow the newly written path. The sweep covers every index on four builds that differ in radix, constant input and local encoding.

// File: rtl/route_mux_pkg.sv
package route_mux_pkg;

    localparam int MAXW = 64;
    localparam int MAXL = 16;

    function automatic int ipow(int b, int e);
        int r = 1;
        for (int i = 0; i < MAXL; i++)
            if (i < e) r = r * b;
        return r;
    endfunction

    function automatic int num_levels(int ni, int radix);
        int l    = 0;
        int span = 1;
        for (int i = 0; i < MAXL; i++)
            if (span < ni) begin
                span = span * radix;
                l++;
            end
        return (l == 0) ? 1 : l;
    endfunction

    function automatic int lvl_fanin(int ni, int radix, int l);
        int below = ipow(radix, l);
        int need  = (ni + below - 1) / below;
        return (need < radix) ? need : radix;
    endfunction

    function automatic int lvl_mems(int f);
        return (f <= 2) ? 1 : f;
    endfunction

    function automatic int lvl_width(int f, bit enc);
        if (lvl_mems(f) == 1) return 1;
        return enc ? $clog2(f) : f;
    endfunction

    function automatic int lvl_offset(int ni, int radix, bit enc, int l);
        int o = 0;
        for (int i = 0; i < MAXL; i++)
            if (i < l) o = o + lvl_width(lvl_fanin(ni, radix, i), enc);
        return o;
    endfunction

    function automatic int cfg_width(int ni, int radix, bit enc);
        return lvl_offset(ni, radix, enc, num_levels(ni, radix));
    endfunction

    // Packed select word that steers input idx to the output.
    function automatic logic [MAXW-1:0] path_word(int idx, int ni, int radix, bit enc);
        logic [MAXW-1:0] w;
        int nl;
        w  = '0;
        nl = num_levels(ni, radix);
        for (int l = 0; l < MAXL; l++) begin
            if (l < nl) begin
                int f;
                int o;
                int d;
                f = lvl_fanin(ni, radix, l);
                o = lvl_offset(ni, radix, enc, l);
                d = (idx / ipow(radix, l)) % radix;
                if (lvl_mems(f) == 1)
                    w[o] = d[0];
                else if (enc) begin
                    for (int b = 0; b < 8; b++)
                        if (b < $clog2(f)) w[o + b] = d[b];
                end else
                    w[o + d] = 1'b1;
            end
        end
        return w;
    endfunction

endpackage

// File: rtl/route_mux_lvl_dec.sv
module route_mux_lvl_dec #(
    parameter int F   = 4,
    parameter int FW  = 2,
    parameter bit ENC = 1'b1
) (
    input  logic [FW-1:0] fld,
    output logic [F-1:0]  sel
);

    generate
        if (F == 2) begin : g_single
            // one stored bit: 1 takes the upper branch
            assign sel = {fld[0], ~fld[0]};
        end else if (ENC) begin : g_dec
            always_comb begin
                for (int i = 0; i < F; i++)
                    sel[i] = (fld == FW'(i));
            end
        end else begin : g_raw
            assign sel = fld;
        end
    endgenerate

endmodule

// File: rtl/route_mux_tree.sv
module route_mux_tree #(
    parameter int NI    = 7,
    parameter int RADIX = 4,
    parameter int NL    = 2
) (
    input  logic [NL*RADIX-1:0] sel,
    input  logic [NI-1:0]       din,
    output logic                dout
);

    localparam int SPAN = RADIX ** NL;

    genvar gl, gj;
    generate
        for (gl = 0; gl < NL; gl++) begin : g_lvl
            localparam int WO = SPAN / (RADIX ** (gl + 1));
            logic [WO*RADIX-1:0] vin;
            logic [WO-1:0]       vout;
            if (gl == 0) begin : g_first
                assign vin = SPAN'(din);
            end else begin : g_next
                assign vin = g_lvl[gl-1].vout;
            end
            for (gj = 0; gj < WO; gj++) begin : g_stage
                assign vout[gj] = |(sel[gl*RADIX +: RADIX] & vin[gj*RADIX +: RADIX]);
            end
        end
    endgenerate

    assign dout = g_lvl[NL-1].vout[0];

endmodule

// File: rtl/route_mux_path_enc.sv
module route_mux_path_enc
    import route_mux_pkg::*;
#(
    parameter int NI        = 7,
    parameter int RADIX     = 4,
    parameter bit LOCAL_ENC = 1'b1,
    parameter int IW        = 4,
    parameter int CW        = 3,
    parameter int DEF_IDX   = 6
) (
    input  logic [IW-1:0] idx,
    output logic [CW-1:0] cfg,
    output logic          err
);

    always_comb begin
        if (int'(idx) >= NI) begin
            err = 1'b1;
            cfg = CW'(path_word(DEF_IDX, NI, RADIX, LOCAL_ENC));
        end else begin
            err = 1'b0;
            cfg = CW'(path_word(int'(idx), NI, RADIX, LOCAL_ENC));
        end
    end

endmodule

// File: rtl/route_mux.sv
module route_mux
    import route_mux_pkg::*;
#(
    parameter int  N_DATA    = 6,
    parameter bit  ADD_CONST = 1'b1,
    parameter bit  CONST_VAL = 1'b1,
    parameter int  RADIX     = 4,
    parameter bit  LOCAL_ENC = 1'b1,
    localparam int NI        = N_DATA + int'(ADD_CONST),
    localparam int NL        = num_levels(NI, RADIX),
    localparam int CW        = cfg_width(NI, RADIX, LOCAL_ENC),
    localparam int IW        = $clog2(NI + 1) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [CW-1:0] cfg_in,
    input  logic [N_DATA-1:0] din,
    output logic          dout,
    input  logic [IW-1:0] req_idx,
    output logic [CW-1:0] req_cfg,
    output logic          req_err
);

    localparam int            DEF_IDX = ADD_CONST ? N_DATA : 0;
    localparam logic [CW-1:0] DEF_CFG = CW'(path_word(DEF_IDX, NI, RADIX, LOCAL_ENC));

    logic [CW-1:0]       cfg_q;
    logic [NI-1:0]       din_full;
    logic [NL*RADIX-1:0] sel_all;

    // configuration register, reset to the idle route
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_q <= DEF_CFG;
        else if (cfg_we) cfg_q <= cfg_in;
    end

    p_cfg_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_q == $past(cfg_in)));
    p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_q));

    generate
        if (ADD_CONST) begin : g_const
            assign din_full = {CONST_VAL, din};
            p_idle_const_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_q == DEF_CFG) |-> (dout == CONST_VAL));
        end else begin : g_plain
            assign din_full = din;
        end
    endgenerate

    genvar gl;
    generate
        for (gl = 0; gl < NL; gl++) begin : g_lvl
            localparam int F   = lvl_fanin(NI, RADIX, gl);
            localparam int FW  = lvl_width(F, LOCAL_ENC);
            localparam int OFF = lvl_offset(NI, RADIX, LOCAL_ENC, gl);
            logic [F-1:0] lsel;

            route_mux_lvl_dec #(.F(F), .FW(FW), .ENC(LOCAL_ENC)) u_dec (
                .fld (cfg_q[OFF +: FW]),
                .sel (lsel)
            );

            assign sel_all[gl*RADIX +: F] = lsel;
            if (F < RADIX) begin : g_pad
                assign sel_all[gl*RADIX+F +: RADIX-F] = '0;
            end

            p_lvl_onehot0_r3: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(lsel));
            p_no_branch_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (lsel == '0) |-> (dout == 1'b0));
        end
    endgenerate

    route_mux_tree #(.NI(NI), .RADIX(RADIX), .NL(NL)) u_tree (
        .sel  (sel_all),
        .din  (din_full),
        .dout (dout)
    );

    route_mux_path_enc #(
        .NI(NI), .RADIX(RADIX), .LOCAL_ENC(LOCAL_ENC),
        .IW(IW), .CW(CW), .DEF_IDX(DEF_IDX)
    ) u_enc (
        .idx (req_idx),
        .cfg (req_cfg),
        .err (req_err)
    );

    p_enc_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(req_idx) >= NI) |-> (req_err && (req_cfg == DEF_CFG)));
    p_enc_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(req_idx) < NI) |-> !req_err);

endmodule

// File: tb/route_mux_unit.sv
module route_mux_unit #(
    parameter int          N_DATA    = 6,
    parameter bit          ADD_CONST = 1'b1,
    parameter bit          CONST_VAL = 1'b1,
    parameter int          RADIX     = 4,
    parameter bit          LOCAL_ENC = 1'b1,
    parameter bit          HAS_HOLE  = 1'b0,
    parameter logic [63:0] HOLE_WORD = 64'h0,
    parameter string       TAG       = "A"
) (
    input  logic clk,
    input  logic rst_n,
    output int   n_chk,
    output int   n_err,
    output logic done
);

    localparam int NI      = N_DATA + int'(ADD_CONST);
    localparam int CW      = route_mux_pkg::cfg_width(NI, RADIX, LOCAL_ENC);
    localparam int IW      = $clog2(NI + 1) + 1;
    localparam int DEF_IDX = ADD_CONST ? N_DATA : 0;

    logic              cfg_we;
    logic [CW-1:0]     cfg_in;
    logic [N_DATA-1:0] din;
    logic              dout;
    logic [IW-1:0]     req_idx;
    logic [CW-1:0]     req_cfg;
    logic              req_err;

    route_mux #(
        .N_DATA(N_DATA), .ADD_CONST(ADD_CONST), .CONST_VAL(CONST_VAL),
        .RADIX(RADIX), .LOCAL_ENC(LOCAL_ENC)
    ) u_route_mux (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_in(cfg_in),
        .din(din), .dout(dout), .req_idx(req_idx), .req_cfg(req_cfg),
        .req_err(req_err)
    );

    // expected word, built level by level from the digit rule
    function automatic logic [63:0] exp_word(int p);
        logic [63:0] w = '0;
        int rem = p;
        int off = 0;
        int pw  = 1;
        for (int l = 0; l < 16; l++) begin
            if (pw < NI) begin
                int f;
                int dg;
                f  = (NI + pw - 1) / pw;
                if (f > RADIX) f = RADIX;
                dg  = rem % RADIX;
                rem = rem / RADIX;
                if (f == 2) begin
                    w[off] = dg[0];
                    off    = off + 1;
                end else if (LOCAL_ENC) begin
                    w   = w | (64'(dg) << off);
                    off = off + $clog2(f);
                end else begin
                    w[off + dg] = 1'b1;
                    off = off + f;
                end
                pw = pw * RADIX;
            end
        end
        return w;
    endfunction

    function automatic logic exp_out(int p, logic [N_DATA-1:0] d);
        return (p < N_DATA) ? d[p] : CONST_VAL;
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL build %s %s: actual %0h expected %0h", TAG, req, act, exp);
        end
    endtask

    initial begin
        n_chk   = 0;
        n_err   = 0;
        done    = 1'b0;
        cfg_we  = 1'b0;
        cfg_in  = '0;
        din     = '0;
        req_idx = '0;
        wait (rst_n === 1'b1);
        @(negedge clk);

        // R7: idle route before any write
        for (int k = 0; k < 3; k++) begin
            din = N_DATA'($urandom);
            #1;
            check(dout == exp_out(DEF_IDX, din), "R7 reset route", 64'(dout),
                  64'(exp_out(DEF_IDX, din)));
            @(negedge clk);
        end

        for (int p = 0; p < NI; p++) begin
            // R4,R5: encoder output for a valid index
            req_idx = IW'(p);
            #1;
            check(!req_err && (64'(req_cfg) == exp_word(p)), "R4,R5 encode",
                  64'(req_cfg), exp_word(p));
            // write while the encoder sees an out-of-range index
            @(negedge clk);
            cfg_in  = CW'(exp_word(p));
            cfg_we  = 1'b1;
            req_idx = IW'(NI);
            #1;
            check(req_err && (64'(req_cfg) == exp_word(DEF_IDX)), "R8 during write",
                  64'(req_cfg), exp_word(DEF_IDX));
            @(negedge clk);
            cfg_we = 1'b0;
            for (int k = 0; k < 4; k++) begin
                din = N_DATA'($urandom);
                #1;
                if (p < N_DATA)
                    check(dout == din[p], "R1 route data", 64'(dout), 64'(din[p]));
                else
                    check(dout == CONST_VAL, "R2 route constant", 64'(dout), 64'(CONST_VAL));
                @(negedge clk);
            end
            // R6: a changing cfg_in without enable leaves the route alone
            cfg_in = ~CW'(exp_word(p));
            @(negedge clk);
            din = N_DATA'($urandom);
            #1;
            check(dout == exp_out(p, din), "R6 hold", 64'(dout), 64'(exp_out(p, din)));
        end

        // R8: other out-of-range requests
        @(negedge clk);
        req_idx = IW'(NI + 1);
        #1;
        check(req_err && (64'(req_cfg) == exp_word(DEF_IDX)), "R8 reject",
              64'(req_cfg), exp_word(DEF_IDX));
        req_idx = '1;
        #1;
        check(req_err && (64'(req_cfg) == exp_word(DEF_IDX)), "R8 reject max",
              64'(req_cfg), exp_word(DEF_IDX));

        // R3: a level field that selects no branch
        if (HAS_HOLE) begin
            @(negedge clk);
            cfg_in = CW'(HOLE_WORD);
            cfg_we = 1'b1;
            @(negedge clk);
            cfg_we = 1'b0;
            for (int k = 0; k < 3; k++) begin
                din = N_DATA'($urandom) | N_DATA'(1);
                #1;
                check(dout == 1'b0, "R3 no branch", 64'(dout), 64'h0);
                @(negedge clk);
            end
        end

        done = 1'b1;
    end

endmodule

// File: tb/route_mux_bench.sv
module route_mux_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic timeout = 1'b0;

    int   chk_a, chk_b, chk_c, chk_d;
    int   err_a, err_b, err_c, err_d;
    logic done_a, done_b, done_c, done_d;

    always #5 clk = ~clk;

    // radix 4, constant 1, binary level fields
    route_mux_unit #(.N_DATA(6), .ADD_CONST(1'b1), .CONST_VAL(1'b1), .RADIX(4),
                     .LOCAL_ENC(1'b1), .TAG("A")) u_a (
        .clk(clk), .rst_n(rst_n), .n_chk(chk_a), .n_err(err_a), .done(done_a));

    // radix 2, no constant, raw fields
    route_mux_unit #(.N_DATA(5), .ADD_CONST(1'b0), .CONST_VAL(1'b0), .RADIX(2),
                     .LOCAL_ENC(1'b0), .TAG("B")) u_b (
        .clk(clk), .rst_n(rst_n), .n_chk(chk_b), .n_err(err_b), .done(done_b));

    // radix 4, no constant, one-hot fields; top group left empty
    route_mux_unit #(.N_DATA(9), .ADD_CONST(1'b0), .CONST_VAL(1'b0), .RADIX(4),
                     .LOCAL_ENC(1'b0), .HAS_HOLE(1'b1), .HOLE_WORD(64'h01),
                     .TAG("C")) u_c (
        .clk(clk), .rst_n(rst_n), .n_chk(chk_c), .n_err(err_c), .done(done_c));

    // radix 4, constant 0, binary fields; top address 3 beyond fan-in 3
    route_mux_unit #(.N_DATA(9), .ADD_CONST(1'b1), .CONST_VAL(1'b0), .RADIX(4),
                     .LOCAL_ENC(1'b1), .HAS_HOLE(1'b1), .HOLE_WORD(64'h0C),
                     .TAG("D")) u_d (
        .clk(clk), .rst_n(rst_n), .n_chk(chk_d), .n_err(err_d), .done(done_d));

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    end

    initial begin
        repeat (100000) @(posedge clk);
        timeout = 1'b1;
    end

    initial begin
        int checks;
        int errors;
        wait ((done_a && done_b && done_c && done_d) || timeout);
        checks = chk_a + chk_b + chk_c + chk_d;
        errors = err_a + err_b + err_c + err_d;
        if (timeout) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected all builds done");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule